// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers 8-bit characters from an asynchronous serial line using one fixed system clock. A runtime setup word selects the bit period, in system clocks, and the framing: parity off, even or odd, and one or two stop bits. Each completed character appears on a parallel output with a one-cycle valid strobe. A parity-error flag and a framing-error flag are raised in the same cycle as the strobe.

The line first passes through a two-flop synchroniser. A falling edge on the idle-high line starts a frame. The start bit is confirmed half a bit period later. From that point every later bit is sampled once per bit period, close to its centre. The setup word is captured when the start edge is seen, so a change to it during a frame only affects later frames.

Top module: `serial_frame_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, then one or two high stop bits. The line idles high. The received byte appears on `rx_data` with `rx_valid` high for exactly one clock cycle.
- R2: With even parity, the expected parity bit is the one that makes the count of ones over data and parity even. Data 0x00 expects 0 and data 0x51 expects 1.
- R3: With odd parity, the expected parity bit makes that count odd. Data 0x00 expects 1, 0x69 expects 1 and 0x7F expects 0.
- R4: `parity_err` is high together with `rx_valid` exactly when parity is enabled and the received parity bit differs from the expected one. `parity_err` and `frame_err` are both low in every cycle where `rx_valid` is low.
- R5: When parity is disabled, the first stop bit directly follows the eighth data bit, and `parity_err` stays low.
- R6: `frame_err` is high with `rx_valid` if any required stop bit is sampled low. This covers the first stop bit and, with two stop bits selected, the second one too.
- R7: A low pulse on the idle line that has ended before the half-bit confirmation point produces no character.
- R8: Layout of the setup word:
  - bits [DIV_W-1:0] hold the clocks per bit;
  - bit DIV_W enables parity;
  - bit DIV_W+1 selects odd parity (0 selects even);
  - bit DIV_W+2 selects two stop bits.
  A divisor of 427 (115200 baud from 49.152 MHz) is supported.
- R9: The setup word is captured when the start edge is detected. Changing it during a frame does not alter how that frame is decoded.
- R10: While reset is high, and in the first cycle after reset is released, `rx_valid`, `parity_err` and `frame_err` are low and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| setup_word | input | DIV_W+3 | Divisor, parity enable, odd select, two-stop select |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| parity_err | output | 1 | Parity mismatch, qualified by rx_valid |
| frame_err | output | 1 | A stop bit was sampled low, qualified by rx_valid |

## Verification
The bench targets the parity corner cases: the all-zero byte under both even and odd parity, and odd and even counts of ones with a deliberately wrong parity bit. A receiver that inverted the rule, or treated zero ones as a special case, would flag good frames or pass corrupted ones.

It drives a low second stop bit. A receiver that checks only the first stop would miss that framing error.

It sends a short glitch. A receiver without half-bit confirmation would deliver a spurious 0xFF.

It changes the setup word mid-frame. A receiver that reads the setup word live would misplace the stop bit and report a false framing error.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Offsets of the framing controls above the divisor field.
  localparam int PEN_OFS = 0;
  localparam int ODD_OFS = 1;
  localparam int TWO_OFS = 2;
  localparam int CTRL_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             half,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // Half a period to reach the start-bit centre, a full period afterwards.
  assign lim  = half ? (div >> 1) : (div - 1'b1);
  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_parity_check.sv
module rx_parity_check #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              enable,
  input  logic              odd,
  input  logic              rx_bit,
  output logic              mismatch
);
  logic expected;

  // Even: the bit balances the ones count to even; odd adds one inversion.
  assign expected = (^data) ^ odd;
  assign mismatch = enable && (rx_bit != expected);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SETUP_W    = DIV_W + CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_line,
  input  logic [SETUP_W-1:0] setup_word,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               parity_err,
  output logic               frame_err
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t        state;
  logic             line_s;
  logic             tick;
  logic [DIV_W-1:0] div_q;
  logic             pen_q, odd_q, two_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0] idx;
  logic             par_q;
  logic             ferr_q;
  logic             par_mis;

  rx_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(rx_line), .q_sync(line_s)
  );

  rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst),
    .restart(state == ST_IDLE),
    .half(state == ST_START),
    .div(div_q),
    .tick(tick)
  );

  rx_parity_check #(.DATA_W(DATA_W)) u_par (
    .data(shreg), .enable(pen_q), .odd(odd_q), .rx_bit(par_q),
    .mismatch(par_mis)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      div_q      <= '0;
      pen_q      <= 1'b0;
      odd_q      <= 1'b0;
      two_q      <= 1'b0;
      shreg      <= '0;
      idx        <= '0;
      par_q      <= 1'b0;
      ferr_q     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!line_s) begin
            div_q <= setup_word[DIV_W-1:0];
            pen_q <= setup_word[DIV_W+PEN_OFS];
            odd_q <= setup_word[DIV_W+ODD_OFS];
            two_q <= setup_word[DIV_W+TWO_OFS];
            state <= ST_START;
          end
        end
        ST_START: if (tick) begin
          idx   <= '0;
          state <= line_s ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (tick) begin
          shreg <= {line_s, shreg[DATA_W-1:1]};
          idx   <= idx + 1'b1;
          if (idx == IDX_W'(DATA_W-1)) state <= pen_q ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (tick) begin
          par_q <= line_s;
          state <= ST_STOP1;
        end
        ST_STOP1: if (tick) begin
          if (two_q) begin
            ferr_q <= !line_s;
            state  <= ST_STOP2;
          end else begin
            rx_valid   <= 1'b1;
            rx_data    <= shreg;
            parity_err <= par_mis;
            frame_err  <= !line_s;
            state      <= ST_IDLE;
          end
        end
        ST_STOP2: if (tick) begin
          rx_valid   <= 1'b1;
          rx_data    <= shreg;
          parity_err <= par_mis;
          frame_err  <= ferr_q || !line_s;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              line_s,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              parity_err,
  input logic              frame_err
);
  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  flags_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> (!parity_err && !frame_err));

  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !frame_err) |-> $past(line_s));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && !parity_err && !frame_err));
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .line_s(line_s), .rx_data(rx_data),
  .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/test_serial_frame_rx.sv
`timescale 1ns/1ps
module test_serial_frame_rx;
  localparam int DATA_W  = 8;
  localparam int DIV_W   = 16;
  localparam int SETUP_W = DIV_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic [SETUP_W-1:0] setup_word = '0;
  logic [DATA_W-1:0] rx_data;
  logic rx_valid, parity_err, frame_err;

  int total = 0;
  int bad   = 0;
  int nvalid = 0;
  logic [7:0] cap_data;
  logic cap_perr, cap_ferr;
  int cur_div = 16;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_frame_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_serial_frame_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line), .setup_word(setup_word),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always @(negedge clk) if (rx_valid) begin
    nvalid++;
    cap_data = rx_data;
    cap_perr = parity_err;
    cap_ferr = frame_err;
  end

  // fields: {flip parity[11], two stop[10], odd[9], parity en[8], data[7:0]}
  localparam logic [11:0] VEC [10] = '{
    12'h100, 12'h151, 12'h369, 12'h37F, 12'h300,
    12'h0A5, 12'h533, 12'hB0F, 12'h951, 12'h4FF
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SETUP_W-1:0] mk_setup(input bit en, input bit odd, input bit two, input int div);
    return {two, odd, en, DIV_W'(div)};
  endfunction

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (cur_div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit en, input bit odd, input bit two,
                      input bit flip, input bit s1_bad, input bit s2_bad,
                      input bit chg, input logic [SETUP_W-1:0] chg_val);
    logic pbit;
    pbit = (^d) ^ odd ^ flip;
    drive_bit(1'b0);
    if (chg) setup_word = chg_val;
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (en) drive_bit(pbit);
    drive_bit(!s1_bad);
    if (two) drive_bit(!s2_bad);
    repeat (3) drive_bit(1'b1);
  endtask

  task automatic expect_byte(input int n0, input string req, input logic [7:0] d,
                             input bit perr, input bit ferr);
    check(nvalid == n0 + 1, req, nvalid - n0, 1);
    check(cap_data == d, req, cap_data, d);
    check(cap_perr == perr, req, cap_perr, perr);
    check(cap_ferr == ferr, req, cap_ferr, ferr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    // R10: outputs quiet in reset
    check(!rx_valid && !parity_err && !frame_err && rx_data == 0, "R10", rx_valid, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!rx_valid && rx_data == 0, "R10", rx_data, 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    foreach (VEC[k]) begin
      logic [11:0] v;
      string tag;
      v = VEC[k];
      tag = !v[8] ? "R5" : (v[11] ? "R4" : (v[9] ? "R3" : "R2"));
      setup_word = mk_setup(v[8], v[9], v[10], 16);
      n0 = nvalid;
      send(v[7:0], v[8], v[9], v[10], v[11], 0, 0, 0, '0);
      expect_byte(n0, tag, v[7:0], v[11] & v[8], 1'b0);
    end

    // R6: second stop low with two stops
    setup_word = mk_setup(1, 0, 1, 16);
    n0 = nvalid;
    send(8'h3C, 1, 0, 1, 0, 0, 1, 0, '0);
    expect_byte(n0, "R6", 8'h3C, 0, 1);

    // R6: first stop low with one stop
    setup_word = mk_setup(0, 0, 0, 16);
    n0 = nvalid;
    send(8'hC3, 0, 0, 0, 0, 1, 0, 0, '0);
    expect_byte(n0, "R6", 8'hC3, 0, 1);

    // R7: short glitch is ignored
    n0 = nvalid;
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (16 * 14) @(negedge clk);
    check(nvalid == n0, "R7", nvalid - n0, 0);

    // R9: setup changed mid-frame (even parity bit of 0x33 is 0)
    setup_word = mk_setup(1, 0, 1, 16);
    n0 = nvalid;
    send(8'h33, 1, 0, 1, 0, 0, 0, 1, mk_setup(0, 1, 0, 16));
    expect_byte(n0, "R9", 8'h33, 0, 0);

    // R8: 427 clocks per bit, odd parity
    cur_div = 427;
    setup_word = mk_setup(1, 1, 0, 427);
    n0 = nvalid;
    send(8'h5A, 1, 1, 0, 0, 0, 0, 0, '0);
    expect_byte(n0, "R8", 8'h5A, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule